// File: doc/BRIEF.md
# One-Time Fuse Program and Read Access Controller

This block sits between a fuse controller's register bank and a one-time-programmable fuse array. It accepts one program request or one read request at a time. Each request carries a packed page/row/column address. A program request sets a single fuse bit, unless a protection rule refuses it. A read request returns one 32-bit row, unless that row is read-blocked. The block reports the outcome on single-cycle done and error pulses. Read data is held on its own output.

The fuse array is modelled as an internal row store whose bits only ever move from 0 to 1. The one exception is a testbench initialisation port, which writes a whole row directly.

Write protection comes in three layers, all taken from register-bank inputs and from the fuse array itself:
- A global program enable.
- A sticky lock over a fixed range of rows in page 0.
- Guard fuses. A guard fuse blocks a row range only once the guard fuse itself has been blown.

After reset, the block walks every page and blows the two anchor fuses of row 0 before it accepts any request.

Top module: `otp_access_ctrl`

## Requirements
- R1: A program address packs page in bits 16:13, row in bits 12:5 and column in bits 4:0. A read address uses bits 16:5 as page and row, and each row holds 32 bits with column n at data bit n. A permitted program of (page,row,col) sets exactly that bit, and a later read of the row returns it.
- R2: While the global program enable input is low, every program request is refused: program-done and program-error both pulse, and the array is unchanged.
- R3: In page 0, while the sticky lock input is high, program requests to rows 44 to 51 are refused. Other rows are unaffected by the sticky lock.
- R4: In page 0, a program request is refused when its row has a guard fuse and that guard fuse reads 1. The guard fuses, given as (row, column) of page 0, are:
  - row 4: guard (4,31)
  - rows 8-11: guard (43,27)
  - rows 12-19: guard (43,11)
  - rows 20-27: guard (43,13)
  - rows 28-35: guard (43,15)
  - row 37: guard (43,28)
  - rows 64-71: guard (43,6)
  - rows 72-79: guard (43,7)
  - rows 80-87: guard (43,8)

  All other rows of page 0 are not guarded.
- R5: In page 2, bits from (row 129, col 0) up to and including (row 255, col 27) are refused while fuse (43,16) of page 0 is 1. Other bits of page 2, and every bit of pages 1 and 3 and above, are never refused by a guard.
- R6: Every accepted program request produces one program-done pulse. Program-error pulses with it when the request is refused or when the set fails. A set fails when the page is at or above the number of implemented pages.
- R7: Reads of page 0 rows 12 to 35 are blocked: they return data 0 and pulse read-error. Every accepted read pulses read-done. A read of an unimplemented page returns 0 without error.
- R8: While reset is applied and during the anchor pass after it, busy is high and no done pulse appears. The pass forces columns 1 and 27 of row 0 in every implemented page to 1, so row 0 reads 0x08000002 on a blank array. Busy falls NUM_PAGES+1 clock cycles after reset release.
- R9: A request is accepted only while busy is low. Busy is then high for one cycle. The done pulse is visible on the cycle after that. A request presented while busy is dropped. If program and read are requested together, the program is taken and the read is dropped.
- R10: Programming a bit that is already 1 succeeds without error and leaves the row unchanged. No request ever clears a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| prog_en_i | input | 1 | Global program enable from the register bank |
| sticky_lock_i | input | 1 | Sticky row-range lock from the register bank |
| pgm_req_i | input | 1 | Program request strobe |
| pgm_addr_i | input | 17 | Program address {page, row, column} |
| rd_req_i | input | 1 | Read request strobe |
| rd_addr_i | input | 12 | Read address {page, row} (address bits 16:5) |
| tinit_we_i | input | 1 | Testbench-only row initialisation strobe |
| tinit_page_i | input | 4 | Page of the row to initialise |
| tinit_row_i | input | 8 | Row to initialise |
| tinit_data_i | input | 32 | Value written into the initialised row |
| busy_o | output | 1 | Anchor pass or a request in progress |
| pgm_done_o | output | 1 | One-cycle pulse: program request finished |
| pgm_err_o | output | 1 | One-cycle pulse with done: program refused or failed |
| rd_done_o | output | 1 | One-cycle pulse: read finished |
| rd_err_o | output | 1 | One-cycle pulse with done: read was blocked |
| rd_data_o | output | 32 | Row data of the last read, held until the next read |

## Verification
A request driven before clock edge N is captured at edge N. It is evaluated at edge N+1, so its done and error pulses and any new read data are due in the half-cycle after edge N+1. The busy level is due after edge N. The scoreboard pushes one expected outcome per accepted request. The monitor pops it at the first falling edge where a done pulse shows, so an early, late, missing or extra pulse turns into a mismatch or an empty-queue failure. The anchor pass is timed by counting falling edges with busy high after reset release. The dropped-request cases check busy and done at the exact falling edges, then read the row back.

// File: rtl/otp_pkg.sv
package otp_pkg;

  localparam int PAGE_W = 4;
  localparam int ROW_W  = 8;
  localparam int COL_W  = 5;
  localparam int ADDR_W = PAGE_W + ROW_W + COL_W;
  localparam int POS_W  = ROW_W + COL_W;
  localparam int DATA_W = 1 << COL_W;
  localparam int ROWS   = 1 << ROW_W;

  // anchor fuses forced after reset in row 0 of every page
  localparam int ANC_COL_LO = 1;
  localparam int ANC_COL_HI = 27;

  localparam logic [ROW_W-1:0] GUARD_ROW   = 8'd43;
  localparam logic [ROW_W-1:0] STICKY_LO   = 8'd44;
  localparam logic [ROW_W-1:0] STICKY_HI   = 8'd51;
  localparam logic [ROW_W-1:0] RDBLK_LO    = 8'd12;
  localparam logic [ROW_W-1:0] RDBLK_HI    = 8'd35;

  localparam logic [PAGE_W-1:0] SYN_PAGE   = 4'd2;
  localparam logic [POS_W-1:0]  SYN_LO     = {8'd129, 5'd0};
  localparam logic [POS_W-1:0]  SYN_HI     = {8'd255, 5'd27};
  localparam logic [COL_W-1:0]  SYN_G_COL  = 5'd16;

  typedef struct packed {
    logic [ROW_W-1:0] lo;
    logic [ROW_W-1:0] hi;
    logic [ROW_W-1:0] g_row;
    logic [COL_W-1:0] g_col;
  } guard_ent_t;

  localparam int N_GUARD = 9;

  localparam guard_ent_t [N_GUARD-1:0] GUARD_TAB = '{
    '{lo: 8'd80, hi: 8'd87, g_row: 8'd43, g_col: 5'd8},
    '{lo: 8'd72, hi: 8'd79, g_row: 8'd43, g_col: 5'd7},
    '{lo: 8'd64, hi: 8'd71, g_row: 8'd43, g_col: 5'd6},
    '{lo: 8'd37, hi: 8'd37, g_row: 8'd43, g_col: 5'd28},
    '{lo: 8'd28, hi: 8'd35, g_row: 8'd43, g_col: 5'd15},
    '{lo: 8'd20, hi: 8'd27, g_row: 8'd43, g_col: 5'd13},
    '{lo: 8'd12, hi: 8'd19, g_row: 8'd43, g_col: 5'd11},
    '{lo: 8'd8,  hi: 8'd11, g_row: 8'd43, g_col: 5'd27},
    '{lo: 8'd4,  hi: 8'd4,  g_row: 8'd4,  g_col: 5'd31}
  };

  typedef enum logic [1:0] {ST_ANCHOR, ST_IDLE, ST_EXEC} state_e;
  typedef enum logic {OP_PGM, OP_RD} op_e;

endpackage

// File: rtl/otp_lock_decode.sv
module otp_lock_decode
  import otp_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              prog_en_i,
  input  logic              sticky_i,
  input  logic              guard_val_i,
  output logic [ROW_W-1:0]  guard_row_o,
  output logic [COL_W-1:0]  guard_col_o,
  output logic              refused_o
);

  logic [PAGE_W-1:0] page;
  logic [ROW_W-1:0]  row;
  logic [POS_W-1:0]  pos;
  logic              guarded;
  logic              sticky_hit;

  assign page = addr_i[ADDR_W-1 -: PAGE_W];
  assign row  = addr_i[COL_W +: ROW_W];
  assign pos  = addr_i[POS_W-1:0];

  // guard fuses always live in page 0; the caller looks the bit up
  always_comb begin
    guarded     = 1'b0;
    sticky_hit  = 1'b0;
    guard_row_o = GUARD_ROW;
    guard_col_o = '0;
    if (page == '0) begin
      sticky_hit = sticky_i && (row >= STICKY_LO) && (row <= STICKY_HI);
      for (int i = 0; i < N_GUARD; i++) begin
        if (row >= GUARD_TAB[i].lo && row <= GUARD_TAB[i].hi) begin
          guarded     = 1'b1;
          guard_row_o = GUARD_TAB[i].g_row;
          guard_col_o = GUARD_TAB[i].g_col;
        end
      end
    end else if (page == SYN_PAGE && pos >= SYN_LO && pos <= SYN_HI) begin
      guarded     = 1'b1;
      guard_col_o = SYN_G_COL;
    end
    refused_o = !prog_en_i || sticky_hit || (guarded && guard_val_i);
  end

endmodule

// File: rtl/otp_fuse_store.sv
module otp_fuse_store
  import otp_pkg::*;
#(
  parameter  int NUM_PAGES = 3,
  localparam int DEPTH     = NUM_PAGES * ROWS,
  localparam int IDX_W     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              init_we_i,
  input  logic [IDX_W-1:0]  init_idx_i,
  input  logic [DATA_W-1:0] init_data_i,
  input  logic              set_we_i,
  input  logic [IDX_W-1:0]  set_idx_i,
  input  logic [DATA_W-1:0] set_mask_i,
  input  logic [IDX_W-1:0]  a_idx_i,
  output logic [DATA_W-1:0] a_data_o,
  input  logic [IDX_W-1:0]  b_idx_i,
  output logic [DATA_W-1:0] b_data_o
);

  logic [DATA_W-1:0] mem [DEPTH];

  // the set path can only OR bits in; only the init path overwrites
  always_ff @(posedge clk) begin
    if (init_we_i) begin
      mem[init_idx_i] <= init_data_i;
    end else if (set_we_i) begin
      mem[set_idx_i] <= mem[set_idx_i] | set_mask_i;
    end
  end

  assign a_data_o = mem[a_idx_i];
  assign b_data_o = mem[b_idx_i];

endmodule

// File: rtl/otp_access_ctrl.sv
module otp_access_ctrl
  import otp_pkg::*;
#(
  parameter int NUM_PAGES = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      prog_en_i,
  input  logic                      sticky_lock_i,
  input  logic                      pgm_req_i,
  input  logic [ADDR_W-1:0]         pgm_addr_i,
  input  logic                      rd_req_i,
  input  logic [ADDR_W-COL_W-1:0]   rd_addr_i,
  input  logic                      tinit_we_i,
  input  logic [PAGE_W-1:0]         tinit_page_i,
  input  logic [ROW_W-1:0]          tinit_row_i,
  input  logic [DATA_W-1:0]         tinit_data_i,
  output logic                      busy_o,
  output logic                      pgm_done_o,
  output logic                      pgm_err_o,
  output logic                      rd_done_o,
  output logic                      rd_err_o,
  output logic [DATA_W-1:0]         rd_data_o
);

  localparam int DEPTH = NUM_PAGES * ROWS;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1;
  localparam logic [DATA_W-1:0] ANC_MASK =
    (DATA_W'(1) << ANC_COL_LO) | (DATA_W'(1) << ANC_COL_HI);

  function automatic logic [IDX_W-1:0] row_idx(logic [PAGE_W-1:0] pg,
                                               logic [ROW_W-1:0] r);
    return IDX_W'({pg, r});
  endfunction

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_pipe_q;
  logic       rst_ln;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_ln = rst_pipe_q[1];

  state_e            state_q, state_d;
  op_e               op_q, op_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  anc_q, anc_d;
  logic              pgm_done_q, pgm_done_d, pgm_err_q, pgm_err_d;
  logic              rd_done_q, rd_done_d, rd_err_q, rd_err_d;
  logic [DATA_W-1:0] rd_data_q, rd_data_d;
  logic              capture, anc_en;

  logic [PAGE_W-1:0] cur_page;
  logic [ROW_W-1:0]  cur_row;
  logic [COL_W-1:0]  cur_col;
  logic              page_ok, rd_blocked;
  logic [ROW_W-1:0]  guard_row;
  logic [COL_W-1:0]  guard_col;
  logic              refused;
  logic [DATA_W-1:0] a_data, b_data;
  logic              set_we;
  logic [IDX_W-1:0]  set_idx;
  logic [DATA_W-1:0] set_mask;

  assign cur_page   = addr_q[ADDR_W-1 -: PAGE_W];
  assign cur_row    = addr_q[COL_W +: ROW_W];
  assign cur_col    = addr_q[COL_W-1:0];
  assign page_ok    = int'(cur_page) < NUM_PAGES;
  assign rd_blocked = (cur_page == '0) && (cur_row >= RDBLK_LO) && (cur_row <= RDBLK_HI);

  otp_lock_decode u_lock (
    .addr_i      (addr_q),
    .prog_en_i   (prog_en_i),
    .sticky_i    (sticky_lock_i),
    .guard_val_i (b_data[guard_col]),
    .guard_row_o (guard_row),
    .guard_col_o (guard_col),
    .refused_o   (refused)
  );

  otp_fuse_store #(.NUM_PAGES(NUM_PAGES)) u_store (
    .clk         (clk),
    .init_we_i   (tinit_we_i && (int'(tinit_page_i) < NUM_PAGES)),
    .init_idx_i  (row_idx(tinit_page_i, tinit_row_i)),
    .init_data_i (tinit_data_i),
    .set_we_i    (set_we),
    .set_idx_i   (set_idx),
    .set_mask_i  (set_mask),
    .a_idx_i     (row_idx(cur_page, cur_row)),
    .a_data_o    (a_data),
    .b_idx_i     (row_idx('0, guard_row)),
    .b_data_o    (b_data)
  );

  // next-state logic
  always_comb begin
    state_d    = state_q;
    op_d       = op_q;
    addr_d     = addr_q;
    anc_d      = anc_q;
    capture    = 1'b0;
    anc_en     = 1'b0;
    pgm_done_d = 1'b0;
    pgm_err_d  = 1'b0;
    rd_done_d  = 1'b0;
    rd_err_d   = 1'b0;
    rd_data_d  = rd_data_q;
    set_we     = 1'b0;
    set_idx    = row_idx(cur_page, cur_row);
    set_mask   = '0;
    case (state_q)
      ST_ANCHOR: begin
        set_we   = 1'b1;
        set_idx  = row_idx(PAGE_W'(anc_q), '0);
        set_mask = ANC_MASK;
        anc_en   = 1'b1;
        anc_d    = anc_q + 1'b1;
        if (anc_q == CNT_W'(NUM_PAGES - 1)) state_d = ST_IDLE;
      end
      ST_IDLE: begin
        if (pgm_req_i) begin
          capture = 1'b1;
          op_d    = OP_PGM;
          addr_d  = pgm_addr_i;
          state_d = ST_EXEC;
        end else if (rd_req_i) begin
          capture = 1'b1;
          op_d    = OP_RD;
          addr_d  = {rd_addr_i, COL_W'(0)};
          state_d = ST_EXEC;
        end
      end
      ST_EXEC: begin
        state_d = ST_IDLE;
        if (op_q == OP_PGM) begin
          pgm_done_d = 1'b1;
          if (refused || !page_ok) begin
            pgm_err_d = 1'b1;
          end else begin
            set_we   = 1'b1;
            set_mask = DATA_W'(1) << cur_col;
          end
        end else begin
          rd_done_d = 1'b1;
          rd_err_d  = rd_blocked;
          rd_data_d = (rd_blocked || !page_ok) ? '0 : a_data;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_ln) begin
    if (!rst_ln) begin
      state_q    <= ST_ANCHOR;
      op_q       <= OP_PGM;
      addr_q     <= '0;
      anc_q      <= '0;
      pgm_done_q <= 1'b0;
      pgm_err_q  <= 1'b0;
      rd_done_q  <= 1'b0;
      rd_err_q   <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      state_q    <= state_d;
      pgm_done_q <= pgm_done_d;
      pgm_err_q  <= pgm_err_d;
      rd_done_q  <= rd_done_d;
      rd_err_q   <= rd_err_d;
      if (capture) begin
        op_q   <= op_d;
        addr_q <= addr_d;
      end
      if (anc_en)    anc_q     <= anc_d;
      if (rd_done_d) rd_data_q <= rd_data_d;
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign pgm_done_o = pgm_done_q;
  assign pgm_err_o  = pgm_err_q;
  assign rd_done_o  = rd_done_q;
  assign rd_err_o   = rd_err_q;
  assign rd_data_o  = rd_data_q;

  // R2: a program evaluated with the enable low must end in done plus error
  a_r2_enable_off_refuses: assert property (@(posedge clk) disable iff (!rst_ln)
    (state_q == ST_EXEC && op_q == OP_PGM && !prog_en_i) |=> (pgm_done_o && pgm_err_o));

  // R7: a blocked read never exposes row contents
  a_r7_blocked_reads_zero: assert property (@(posedge clk) disable iff (!rst_ln)
    (rd_done_o && rd_err_o) |-> (rd_data_o == '0));

  // R9: done pulses last one cycle and never coincide
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_ln)
    (pgm_done_o || rd_done_o) |=> !(pgm_done_o || rd_done_o));

  a_r9_one_kind: assert property (@(posedge clk) disable iff (!rst_ln)
    $onehot0({pgm_done_o, rd_done_o}));

  // R9: a done pulse follows a cycle in which the block was busy
  a_r9_done_after_busy: assert property (@(posedge clk) disable iff (!rst_ln)
    (pgm_done_o || rd_done_o) |-> $past(busy_o));

endmodule

// File: tb/otp_access_ctrl_test.sv
module otp_access_ctrl_test;

  localparam int NP = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        prog_en, sticky, pgm_req, rd_req, tinit_we;
  logic [16:0] pgm_addr;
  logic [11:0] rd_addr;
  logic [3:0]  tinit_page;
  logic [7:0]  tinit_row;
  logic [31:0] tinit_data;
  logic        busy, pgm_done, pgm_err, rd_done, rd_err;
  logic [31:0] rd_data;

  always #4 clk = ~clk;

  otp_access_ctrl #(.NUM_PAGES(NP)) uut (
    .clk(clk), .rst_n(rst_n), .prog_en_i(prog_en), .sticky_lock_i(sticky),
    .pgm_req_i(pgm_req), .pgm_addr_i(pgm_addr), .rd_req_i(rd_req), .rd_addr_i(rd_addr),
    .tinit_we_i(tinit_we), .tinit_page_i(tinit_page), .tinit_row_i(tinit_row),
    .tinit_data_i(tinit_data), .busy_o(busy), .pgm_done_o(pgm_done), .pgm_err_o(pgm_err),
    .rd_done_o(rd_done), .rd_err_o(rd_err), .rd_data_o(rd_data)
  );

  typedef struct {
    bit          is_rd;
    bit          err;
    logic [31:0] data;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int   checks = 0;
  int   fails  = 0;
  bit   finished = 1'b0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // monitor: pop one expected outcome per done pulse
  always @(negedge clk) begin : mon
    exp_t e;
    if (rst_n && (pgm_done || rd_done)) begin
      if (pgm_done && rd_done) chk("R9 both done pulses", 32'd1, 32'd0);
      if (sb.size() == 0) begin
        chk("R9 done with nothing expected", 32'd1, 32'd0);
      end else begin
        e = sb.pop_front();
        chk({e.tag, " kind"}, {31'd0, rd_done}, {31'd0, e.is_rd});
        chk({e.tag, " err"}, {31'd0, rd_done ? rd_err : pgm_err}, {31'd0, e.err});
        if (e.is_rd) chk({e.tag, " data"}, rd_data, e.data);
      end
    end
  end

  task automatic pgm(int pg, int row, int col, bit err, string tag);
    @(negedge clk);
    pgm_req  = 1'b1;
    pgm_addr = {4'(pg), 8'(row), 5'(col)};
    sb.push_back('{is_rd: 1'b0, err: err, data: 32'h0, tag: tag});
    @(negedge clk);
    pgm_req = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic rd(int pg, int row, logic [31:0] data, bit err, string tag);
    @(negedge clk);
    rd_req  = 1'b1;
    rd_addr = {4'(pg), 8'(row)};
    sb.push_back('{is_rd: 1'b1, err: err, data: data, tag: tag});
    @(negedge clk);
    rd_req = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic init_row(int pg, int row, logic [31:0] data);
    @(negedge clk);
    tinit_we   = 1'b1;
    tinit_page = 4'(pg);
    tinit_row  = 8'(row);
    tinit_data = data;
    @(negedge clk);
    tinit_we = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin : stim
    int busy_cnt;
    rst_n = 1'b0; prog_en = 1'b0; sticky = 1'b0; pgm_req = 1'b0; rd_req = 1'b0;
    tinit_we = 1'b0; pgm_addr = '0; rd_addr = '0;
    tinit_page = '0; tinit_row = '0; tinit_data = '0;

    // blank the array while reset is held
    for (int p = 0; p < NP; p++) begin
      for (int r = 0; r < 256; r++) begin
        @(negedge clk);
        tinit_we = 1'b1; tinit_page = 4'(p); tinit_row = 8'(r); tinit_data = '0;
      end
    end
    @(negedge clk);
    tinit_we = 1'b0;
    chk("R8 busy in reset", {31'd0, busy}, 32'd1);
    chk("R8 no pgm done in reset", {31'd0, pgm_done}, 32'd0);
    chk("R8 no rd done in reset", {31'd0, rd_done}, 32'd0);
    chk("R8 rd data in reset", rd_data, 32'd0);

    rst_n = 1'b1;
    busy_cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (busy) busy_cnt++;
    end
    chk("R8 anchor pass length", 32'(busy_cnt), 32'(NP + 1));

    for (int p = 0; p < NP; p++) rd(p, 0, 32'h0800_0002, 1'b0, "R8 anchor row");

    // R1 basic programming and readback
    prog_en = 1'b1;
    pgm(1, 5, 3, 1'b0, "R1 set col3");
    rd(1, 5, 32'h0000_0008, 1'b0, "R1 read col3");
    pgm(1, 5, 31, 1'b0, "R1 set col31");
    rd(1, 5, 32'h8000_0008, 1'b0, "R1 read col31");
    pgm(0, 100, 0, 1'b0, "R1 page0 row100");
    rd(0, 100, 32'h0000_0001, 1'b0, "R1 read page0 row100");

    // R10 reprogramming a set bit
    pgm(1, 5, 3, 1'b0, "R10 reprogram set bit");
    rd(1, 5, 32'h8000_0008, 1'b0, "R10 row unchanged");
    pgm(0, 0, 27, 1'b0, "R10 reprogram anchor");
    rd(0, 0, 32'h0800_0002, 1'b0, "R10 anchor row unchanged");

    // R2 global enable
    prog_en = 1'b0;
    pgm(1, 5, 0, 1'b1, "R2 enable low refused");
    rd(1, 5, 32'h8000_0008, 1'b0, "R2 array unchanged");
    prog_en = 1'b1;

    // R3 sticky lock range
    sticky = 1'b1;
    pgm(0, 44, 0, 1'b1, "R3 row44 locked");
    pgm(0, 51, 2, 1'b1, "R3 row51 locked");
    pgm(0, 43, 31, 1'b0, "R3 row43 open");
    pgm(0, 52, 0, 1'b0, "R3 row52 open");
    rd(0, 44, 32'h0, 1'b0, "R3 row44 untouched");
    sticky = 1'b0;
    pgm(0, 44, 0, 1'b0, "R3 row44 after unlock");
    rd(0, 44, 32'h1, 1'b0, "R3 row44 set");

    // R4 guard table
    pgm(0, 70, 1, 1'b0, "R4 row70 guard clear");
    pgm(0, 43, 6, 1'b0, "R4 blow guard 43.6");
    pgm(0, 70, 2, 1'b1, "R4 row70 guarded");
    rd(0, 70, 32'h0000_0002, 1'b0, "R4 row70 content");
    pgm(0, 72, 0, 1'b0, "R4 row72 other guard clear");
    pgm(0, 4, 5, 1'b0, "R4 row4 open");
    pgm(0, 4, 31, 1'b0, "R4 blow self guard");
    pgm(0, 4, 6, 1'b1, "R4 row4 guarded");
    rd(0, 4, 32'h8000_0020, 1'b0, "R4 row4 content");
    pgm(0, 36, 0, 1'b0, "R4 row36 unguarded");
    pgm(0, 37, 0, 1'b0, "R4 row37 guard clear");
    pgm(0, 43, 28, 1'b0, "R4 blow guard 43.28");
    pgm(0, 37, 1, 1'b1, "R4 row37 guarded");

    // R7 read blocking
    init_row(0, 20, 32'h0000_FFFF);
    rd(0, 20, 32'h0, 1'b1, "R7 row20 blocked");
    rd(0, 12, 32'h0, 1'b1, "R7 row12 blocked");
    rd(0, 35, 32'h0, 1'b1, "R7 row35 blocked");
    rd(0, 11, 32'h0, 1'b0, "R7 row11 readable");
    rd(0, 36, 32'h1, 1'b0, "R7 row36 readable");

    // R5 page 2 range guard
    pgm(2, 129, 0, 1'b0, "R5 range guard clear");
    pgm(2, 128, 31, 1'b0, "R5 below range");
    pgm(0, 43, 16, 1'b0, "R5 blow guard 43.16");
    pgm(2, 200, 5, 1'b1, "R5 mid range guarded");
    pgm(2, 255, 27, 1'b1, "R5 range end guarded");
    pgm(2, 255, 28, 1'b0, "R5 past range end");
    pgm(2, 129, 1, 1'b1, "R5 range start guarded");
    pgm(1, 200, 5, 1'b0, "R5 page1 never guarded");
    rd(2, 200, 32'h0, 1'b0, "R5 row200 unchanged");
    rd(2, 255, 32'h1000_0000, 1'b0, "R5 row255 content");
    rd(2, 129, 32'h0000_0001, 1'b0, "R5 row129 content");

    // R6 failed set on unimplemented pages
    pgm(3, 0, 0, 1'b1, "R6 page3 set fails");
    pgm(15, 7, 7, 1'b1, "R6 page15 set fails");
    rd(3, 0, 32'h0, 1'b0, "R6 page3 read zero");

    // R9 timing and drop while busy
    @(negedge clk);
    pgm_req = 1'b1; pgm_addr = {4'd1, 8'd9, 5'd0};
    sb.push_back('{is_rd: 1'b0, err: 1'b0, data: 32'h0, tag: "R9 first program"});
    @(negedge clk);
    chk("R9 busy after accept", {31'd0, busy}, 32'd1);
    chk("R9 no done yet", {31'd0, pgm_done}, 32'd0);
    pgm_addr = {4'd1, 8'd9, 5'd1};
    @(negedge clk);
    chk("R9 done on time", {31'd0, pgm_done}, 32'd1);
    pgm_req = 1'b0;
    repeat (3) @(negedge clk);
    rd(1, 9, 32'h0000_0001, 1'b0, "R9 busy request dropped");

    // R9 program wins over simultaneous read
    @(negedge clk);
    pgm_req = 1'b1; pgm_addr = {4'd1, 8'd10, 5'd0};
    rd_req  = 1'b1; rd_addr  = {4'd1, 8'd10};
    sb.push_back('{is_rd: 1'b0, err: 1'b0, data: 32'h0, tag: "R9 program priority"});
    @(negedge clk);
    pgm_req = 1'b0; rd_req = 1'b0;
    repeat (3) @(negedge clk);
    rd(1, 10, 32'h0000_0001, 1'b0, "R9 row after priority");

    repeat (4) @(negedge clk);
    chk("R9 scoreboard drained", 32'(sb.size()), 32'd0);
    finish_run();
  end

endmodule